// File: doc/BRIEF.md
# Hash Chain Step Sequencer

This block computes the chain function of a Winternitz-style one-time signature. Given a 256-bit start value, a start position `i` and a step count `j`, it applies the chain step `j` times. Each step uses three hash calls. Two pseudorandom calls over the seed and a rewritten address word produce a step key and a bitmask. A third call hashes the key together with the current value XORed with the mask. The hash core is not part of this block. Every call goes out through a sponge port that moves 128 bits per operation. The first operation of a call uses a start request and the rest use continue requests. The block waits for a completion pulse after each operation.

A controller loads the operands and pulses `start`. It then waits for `hc_done`, which means `hc_out` holds the result, or for `hc_err`, which means the requested span runs past the end of the chain.

Top module: `hash_chain_seq`

## Requirements
- R1: After reset `hc_out` is zero, and `hc_done`, `hc_err`, `hc_busy`, `sp_start`, `sp_cont` and `sp_squeeze` are all low.
- R2: A start with `j_in` = 0 and `i_in` ≤ W-1 gives `hc_out` = `s_in` with a single `hc_done` pulse. No sponge request is issued.
- R3: A start with `i_in + j_in` > W-1 (W = 16) gives a single `hc_err` pulse. There is no `hc_done`, no sponge request, and `hc_out` keeps its previous value.
- R4: Otherwise the result is v_j, where v_0 = S and v_(k+1) = F(K_k, v_k XOR M_k). K_k and M_k are PRF(SEED, A) calls with the address word A prepared as R5 describes.
- R5: In each PRF call the address word has bits [63:32] set to the position i+k and bits [31:0] set to 0 for the key call or 1 for the mask call. All other address bits pass through unchanged. The key call comes first, then the mask call, then F.
- R6: Each call hashes a 512-bit message: {ADDR, SEED} for PRF and {v XOR M, K} for F. The message is sent as four 128-bit chunks, least significant first. A squeeze with zero data follows. The 256-bit result is {squeeze output, fourth-chunk output}.
- R7: Every call is exactly five sponge operations. The first uses `sp_start`, the next four use `sp_cont`, and the fifth also raises `sp_squeeze`. A run of j steps issues 3j starts, 12j continues and 3j squeezes.
- R8: At most one sponge operation is outstanding. No new request is issued until `sp_done` has answered the previous one.
- R9: `hc_done` and `hc_err` are single-cycle pulses and never high together.
- R10: A `start` that arrives while the block is busy is ignored. The running chain ends with the same result it would have produced anyway.
- R11: `hc_busy` is high from the cycle after an accepted start with j > 0 until the cycle in which `hc_done` rises. In that cycle it is low, and requests occur only while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain run (one cycle) |
| s_in | input | 256 | Chain start value |
| i_in | input | 4 | Start position |
| j_in | input | 4 | Number of steps |
| seed_in | input | 256 | Public seed |
| addr_in | input | 256 | Address word template |
| hc_out | output | 256 | Current or final chain value |
| hc_done | output | 1 | Result valid pulse |
| hc_err | output | 1 | Span out of range pulse |
| hc_busy | output | 1 | Run in progress |
| sp_start | output | 1 | First sponge operation of a call |
| sp_cont | output | 1 | Later sponge operation of a call |
| sp_squeeze | output | 1 | This operation is the squeeze |
| sp_din | output | 128 | Sponge operation data |
| sp_dout | input | 128 | Sponge operation result |
| sp_done | input | 1 | Sponge operation complete |

## Verification
The bench builds the block with its default parameters: W = 16, a 256-bit value width and a 128-bit sponge lane. Its sponge stand-in answers two cycles after each request. With these sizes the bench can sweep every one of the 256 (i, j) pairs. That covers every out-of-range span, every zero-step run and every valid chain up to the full 15 steps. Each result is compared against a chain built arithmetically from the same stand-in mixing function, and each run's sponge operations are counted against 3j, 12j and 3j.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
    typedef enum logic [1:0] {
        HC_IDLE  = 2'd0,
        HC_ISSUE = 2'd1,
        HC_WAIT  = 2'd2
    } hc_state_e;

    typedef enum logic [1:0] {
        CALL_KEY  = 2'd0,
        CALL_MASK = 2'd1,
        CALL_F    = 2'd2
    } hc_call_e;
endpackage

// File: rtl/hcs_addr_fmt.sv
// Rewrites the position and key/mask fields of the address word.
module hcs_addr_fmt #(
    parameter int DW     = 256,
    parameter int FW     = 32,
    parameter int KM_LSB = 0,
    parameter int HA_LSB = 32,
    parameter int PW     = 5
) (
    input  logic [DW-1:0] addr_i,
    input  logic [PW-1:0] pos_i,
    input  logic          mask_sel_i,
    output logic [DW-1:0] addr_o
);
    always_comb begin
        addr_o                = addr_i;
        addr_o[KM_LSB +: FW]  = FW'(mask_sel_i);
        addr_o[HA_LSB +: FW]  = FW'(pos_i);
    end
endmodule

// File: rtl/hcs_chunk_sel.sv
// Picks the sponge lane for one operation of a call; the squeeze carries zero.
module hcs_chunk_sel #(
    parameter int DW  = 256,
    parameter int RW  = 128,
    parameter int OPW = 3
) (
    input  logic [2*DW-1:0] msg_i,
    input  logic [OPW-1:0]  sel_i,
    input  logic            squeeze_i,
    output logic [RW-1:0]   chunk_o
);
    localparam int NCH = (2 * DW) / RW;

    logic [RW-1:0] parts [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_part
        assign parts[g] = msg_i[g*RW +: RW];
    end

    always_comb begin
        chunk_o = '0;
        for (int k = 0; k < NCH; k++) begin
            if (!squeeze_i && sel_i == OPW'(k)) begin
                chunk_o = parts[k];
            end
        end
    end
endmodule

// File: rtl/hash_chain_seq.sv
module hash_chain_seq
    import hcs_pkg::*;
#(
    parameter int W      = 16,
    parameter int DW     = 256,
    parameter int RW     = 128,
    parameter int FW     = 32,
    parameter int KM_LSB = 0,
    parameter int HA_LSB = 32,
    parameter int CW     = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] s_in,
    input  logic [CW-1:0] i_in,
    input  logic [CW-1:0] j_in,
    input  logic [DW-1:0] seed_in,
    input  logic [DW-1:0] addr_in,
    output logic [DW-1:0] hc_out,
    output logic          hc_done,
    output logic          hc_err,
    output logic          hc_busy,
    output logic          sp_start,
    output logic          sp_cont,
    output logic          sp_squeeze,
    output logic [RW-1:0] sp_din,
    input  logic [RW-1:0] sp_dout,
    input  logic          sp_done
);
    localparam int NCH  = (2 * DW) / RW;
    localparam int NOPS = NCH + 1;
    localparam int OPW  = $clog2(NOPS);
    localparam int PW   = CW + 1;
    localparam logic [PW-1:0] LAST_POS = PW'(W - 1);
    localparam logic [OPW-1:0] OP_SQZ  = OPW'(NOPS - 1);
    localparam logic [OPW-1:0] OP_LAST = OPW'(NOPS - 2);

    typedef struct packed {
        hc_state_e      st;
        hc_call_e       call;
        logic [OPW-1:0] op;
        logic [PW-1:0]  pos;
        logic [PW-1:0]  left;
        logic [DW-1:0]  val;
        logic [DW-1:0]  key;
        logic [DW-1:0]  bm;
        logic [DW-1:0]  seed;
        logic [DW-1:0]  addr;
        logic [RW-1:0]  lo;
        logic           done;
        logic           err;
    } regs_t;

    regs_t q, d;

    logic [DW-1:0]   addr_fmt;
    logic [2*DW-1:0] msg;
    logic [PW-1:0]   span_end;
    logic [DW-1:0]   call_res;

    hcs_addr_fmt #(
        .DW(DW), .FW(FW), .KM_LSB(KM_LSB), .HA_LSB(HA_LSB), .PW(PW)
    ) u_addr (
        .addr_i    (q.addr),
        .pos_i     (q.pos),
        .mask_sel_i(q.call == CALL_MASK),
        .addr_o    (addr_fmt)
    );

    assign msg = (q.call == CALL_F) ? {q.val ^ q.bm, q.key} : {addr_fmt, q.seed};

    hcs_chunk_sel #(
        .DW(DW), .RW(RW), .OPW(OPW)
    ) u_chunk (
        .msg_i    (msg),
        .sel_i    (q.op),
        .squeeze_i(q.op == OP_SQZ),
        .chunk_o  (sp_din)
    );

    assign span_end = PW'(i_in) + PW'(j_in);
    assign call_res = {sp_dout, q.lo};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            HC_IDLE: begin
                if (start) begin
                    if (span_end > LAST_POS) begin
                        d.err = 1'b1;
                    end else if (j_in == '0) begin
                        d.val  = s_in;
                        d.done = 1'b1;
                    end else begin
                        d.val  = s_in;
                        d.pos  = PW'(i_in);
                        d.left = PW'(j_in);
                        d.seed = seed_in;
                        d.addr = addr_in;
                        d.call = CALL_KEY;
                        d.op   = '0;
                        d.st   = HC_ISSUE;
                    end
                end
            end
            HC_ISSUE: d.st = HC_WAIT;
            HC_WAIT: begin
                if (sp_done) begin
                    if (q.op == OP_SQZ) begin
                        d.op = '0;
                        d.st = HC_ISSUE;
                        case (q.call)
                            CALL_KEY: begin
                                d.key  = call_res;
                                d.call = CALL_MASK;
                            end
                            CALL_MASK: begin
                                d.bm   = call_res;
                                d.call = CALL_F;
                            end
                            default: begin
                                d.val  = call_res;
                                d.pos  = q.pos + 1'b1;
                                d.left = q.left - 1'b1;
                                d.call = CALL_KEY;
                                if (q.left == PW'(1)) begin
                                    d.st   = HC_IDLE;
                                    d.done = 1'b1;
                                end
                            end
                        endcase
                    end else begin
                        if (q.op == OP_LAST) begin
                            d.lo = sp_dout;
                        end
                        d.op = q.op + 1'b1;
                        d.st = HC_ISSUE;
                    end
                end
            end
            default: d.st = HC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hc_out     = q.val;
    assign hc_done    = q.done;
    assign hc_err     = q.err;
    assign hc_busy    = (q.st != HC_IDLE);
    assign sp_start   = (q.st == HC_ISSUE) && (q.op == '0);
    assign sp_cont    = (q.st == HC_ISSUE) && (q.op != '0);
    assign sp_squeeze = (q.st == HC_ISSUE) && (q.op == OP_SQZ);
endmodule

// File: rtl/hcs_checker.sv
module hcs_checker (
    input logic clk,
    input logic rst_n,
    input logic hc_done,
    input logic hc_err,
    input logic hc_busy,
    input logic sp_start,
    input logic sp_cont,
    input logic sp_squeeze,
    input logic sp_done
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (sp_start || sp_cont) begin
            pend_q <= 1'b1;
        end else if (sp_done) begin
            pend_q <= 1'b0;
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        hc_done |=> !hc_done);
    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        hc_err |=> !hc_err);
    a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hc_done && hc_err));
    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !(sp_start || sp_cont));
    a_r7_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sp_start && sp_cont));
    a_r7_squeeze_on_cont: assert property (@(posedge clk) disable iff (!rst_n)
        sp_squeeze |-> sp_cont);
    a_r11_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        hc_done |-> !hc_busy);
    a_r11_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_start || sp_cont) |-> hc_busy);
    a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hc_err |-> (!hc_busy && !sp_start && !sp_cont));
endmodule

bind hash_chain_seq hcs_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hc_done   (hc_done),
    .hc_err    (hc_err),
    .hc_busy   (hc_busy),
    .sp_start  (sp_start),
    .sp_cont   (sp_cont),
    .sp_squeeze(sp_squeeze),
    .sp_done   (sp_done)
);

// File: tb/hash_chain_seq_tb_top.sv
module hash_chain_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 16;
    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] s_in = '0, seed_in = '0, addr_in = '0;
    logic [3:0]   i_in = '0, j_in = '0;
    logic [255:0] hc_out;
    logic         hc_done, hc_err, hc_busy;
    logic         sp_start, sp_cont, sp_squeeze, sp_done;
    logic [127:0] sp_din, sp_dout;

    int total = 0, fails = 0;
    int n_start = 0, n_cont = 0, n_sq = 0, n_overlap = 0;
    logic [127:0] sb_state;
    int sb_cnt;
    logic [255:0] last_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hash_chain_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .s_in(s_in), .i_in(i_in),
        .j_in(j_in), .seed_in(seed_in), .addr_in(addr_in), .hc_out(hc_out),
        .hc_done(hc_done), .hc_err(hc_err), .hc_busy(hc_busy),
        .sp_start(sp_start), .sp_cont(sp_cont), .sp_squeeze(sp_squeeze),
        .sp_din(sp_din), .sp_dout(sp_dout), .sp_done(sp_done)
    );

    function automatic logic [127:0] mix(input logic [127:0] s, input logic [127:0] v);
        mix = ({s[120:0], s[127:121]} + v) ^ {s[63:0], s[127:64]}
              ^ 128'h243F6A8885A308D313198A2E03707344;
    endfunction

    // Sponge stand-in: answers each request LAT cycles later.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_done <= 1'b0; sp_dout <= '0; sb_state <= '0; sb_cnt <= 0;
        end else begin
            sp_done <= 1'b0;
            if (sp_start || sp_cont) begin
                if (sb_cnt != 0 || sp_done) n_overlap <= n_overlap + 1;
                if (sp_start) sb_state <= mix('0, sp_din);
                else if (sp_squeeze) sb_state <= mix(sb_state, '0);
                else sb_state <= mix(sb_state, sp_din);
                sb_cnt <= LAT;
                if (sp_start) n_start <= n_start + 1;
                if (sp_cont) n_cont <= n_cont + 1;
                if (sp_squeeze) n_sq <= n_sq + 1;
            end else if (sb_cnt == 1) begin
                sp_done <= 1'b1; sp_dout <= sb_state; sb_cnt <= 0;
            end else if (sb_cnt > 1) begin
                sb_cnt <= sb_cnt - 1;
            end
        end
    end

    function automatic logic [255:0] call_model(input logic [511:0] m);
        logic [127:0] s, lo;
        s = mix('0, m[127:0]);
        s = mix(s, m[255:128]);
        s = mix(s, m[383:256]);
        s = mix(s, m[511:384]);
        lo = s;
        s = mix(s, '0);
        return {s, lo};
    endfunction

    function automatic logic [255:0] chain_model(input logic [255:0] s, input int i,
            input int j, input logic [255:0] seed, input logic [255:0] addr);
        logic [255:0] v, k, m, a;
        v = s;
        for (int n = 0; n < j; n++) begin
            a = addr;
            a[63:32] = 32'(i + n);
            a[31:0]  = 32'd0;
            k = call_model({a, seed});
            a[31:0]  = 32'd1;
            m = call_model({a, seed});
            v = call_model({v ^ m, k});
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_chain(input logic [255:0] s, input int i, input int j,
            input logic [255:0] seed, input logic [255:0] addr, input bit inject);
        int s0, c0, q0, cyc;
        bit bad, sd, se;
        logic [255:0] exp;
        bad = (i + j > W - 1);
        exp = chain_model(s, i, j, seed, addr);
        s0 = n_start; c0 = n_cont; q0 = n_sq;
        @(negedge clk);
        s_in = s; i_in = 4'(i); j_in = 4'(j); seed_in = seed; addr_in = addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!bad && j != 0) chk(hc_busy, "R11", 256'(hc_busy), 256'd1);
        cyc = 0;
        while (!(hc_done || hc_err) && cyc < 20000) begin
            if (inject && cyc == 5) begin
                // R10: a start while busy must not disturb the run
                start = 1'b1; s_in = ~s; i_in = 4'd0; j_in = 4'd0;
                seed_in = ~seed; addr_in = ~addr;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (cyc >= 20000) chk(1'b0, "R4 timeout", '0, '0);
        sd = hc_done; se = hc_err;
        if (bad) begin
            chk(se && !sd, "R3", {254'd0, sd, se}, 256'd1);
            chk(hc_out == last_out, "R3", hc_out, last_out);
            chk(n_start == s0 && n_cont == c0, "R3", 256'(n_start - s0 + n_cont - c0), '0);
        end else begin
            chk(sd && !se, j == 0 ? "R2" : "R4", {254'd0, sd, se}, 256'd2);
            chk(hc_out == exp, inject ? "R10" : (j == 0 ? "R2" : "R4 R5 R6"), hc_out, exp);
            chk(!hc_busy, "R11", 256'(hc_busy), '0);
            if (j == 0) chk(n_start == s0 && n_cont == c0, "R2", 256'(n_start - s0), '0);
            chk(n_start - s0 == 3 * j, "R7", 256'(n_start - s0), 256'(3 * j));
            chk(n_cont - c0 == 12 * j, "R7", 256'(n_cont - c0), 256'(12 * j));
            chk(n_sq - q0 == 3 * j, "R7", 256'(n_sq - q0), 256'(3 * j));
            last_out = exp;
        end
        @(negedge clk);
        chk(!hc_done && !hc_err, "R9", {254'd0, hc_done, hc_err}, '0);
    endtask

    bit finished = 0;

    initial begin
        #(CLK_PERIOD * 195000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(hc_out == '0 && !hc_done && !hc_err && !hc_busy, "R1", hc_out, '0);
        chk(!sp_start && !sp_cont && !sp_squeeze, "R1",
            {253'd0, sp_start, sp_cont, sp_squeeze}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hc_out == '0 && !hc_done && !hc_busy, "R1", hc_out, '0);
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                logic [255:0] s, sd, ad;
                s  = {8{32'(i * 977 + j * 31 + 5)}};
                sd = {8{32'hA5C3_0F11 ^ 32'(j * 65537)}};
                ad = {64'h1111_2222_3333_4444, 32'hC0DE_0000 + 32'(i), 32'h0000_7777,
                      32'hFFFF_0000, 32'(j + 9), 32'hDEAD_BEEF, 32'hFFFF_FFFF};
                run_chain(s, i, j, sd, ad, 1'b0);
            end
        end
        run_chain({4{64'h0123_4567_89AB_CDEF}}, 2, 10, {8{32'h5555_AAAA}},
                  {8{32'h1357_9BDF}}, 1'b1);
        chk(n_overlap == 0, "R8", 256'(n_overlap), '0);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule